// File: doc/BRIEF.md
# Privilege-Level Interrupt Delegation Router

This block sits beside a hart's trap logic. Every cycle it looks at the pending and enable vectors for the twelve interrupt sources. A source is one of three kinds (software, timer, external) raised for one of four privilege levels: user, supervisor, hypervisor or machine. For each source that is both pending and enabled, the block works out which privilege level handles it by walking a chain of three delegation registers. It then decides whether that level may take the interrupt now, given the hart's current privilege level and the per-level global interrupt enables.

Of all the sources that qualify, the block picks one. It presents a registered trap decision: a take strobe, the handling privilege level, the cause value to write into that level's cause register, and a one-hot select for that level's trap-vector register. The cause is rewritten to the handling level's own number for the interrupt kind. For example, a machine timer interrupt handled by the supervisor reports the supervisor timer cause. The CSR datapath, the pipeline flush and the real vector addresses belong to the surrounding core.

Top module: `irq_deleg_router`

## Requirements
- R1: A synchronous active-high reset clears take, target level, cause and vector select to zero on the next clock edge.
- R2: Source bit i of the pending and enable vectors is routed by bit i of each delegation register. Machine bit 0 gives level M. Machine 1 with hypervisor 0 gives H. Machine 1, hypervisor 1 and supervisor 0 gives S. All three set gives U. Source bits are: software U/S/H/M at 0..3, timer U/S/H/M at 4..7, external U/S/H/M at 8..11.
- R3: Levels are encoded U=0, S=1, H=2, M=3. While take is 1, the vector select is one-hot with bit n set for target level n. While take is 0, the vector select, target level and cause are all zero.
- R4: A source whose target level is below the current privilege level is not taken.
- R5: A source whose target level is above the current level is taken whatever the global enables hold.
- R6: A source whose target level equals the current level is taken only if the global enable bit of that level (gie bit n for level n) is 1.
- R7: The cause has bit CAUSE_W-1 set, and its low four bits hold 4*kind + target level, with kind software=0, timer=1, external=2. The rest of the cause is zero. A timer routed to S therefore reports 5, and an external routed to S reports 9.
- R8: When several sources are eligible, the winner is the one with the highest target level.
- R9: Among eligible sources with the same target level, external beats software, and software beats timer.
- R10: A source that is not both pending and enabled is never taken, and it does not affect the choice.
- R11: The outputs reflect the inputs sampled at the previous clock edge: one cycle of latency. The take strobe stays high for as long as an eligible source remains, and it drops the cycle after none remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 12 | Interrupt pending vector |
| en_i | input | 12 | Interrupt enable vector |
| deleg_m_i | input | 12 | Machine-level delegation bits |
| deleg_h_i | input | 12 | Hypervisor-level delegation bits |
| deleg_s_i | input | 12 | Supervisor-level delegation bits |
| gie_i | input | 4 | Global interrupt enable per level, bit n for level n |
| cur_lvl_i | input | 2 | Current privilege level of the hart |
| take_o | output | 1 | Take an interrupt trap this cycle |
| tgt_lvl_o | output | 2 | Privilege level that handles the trap |
| cause_o | output | CAUSE_W | Cause value with the interrupt flag in the top bit |
| vec_sel_o | output | 4 | One-hot select of the target level's vector register |

## Verification
Suppose a source's target level is computed wrongly inside the block. The error shows on the ports one cycle after the stimulus: the target level is wrong, the low cause bits are wrong, and the vector select bit is wrong, all three together. It can also show as a take strobe where the below-current rule should have blocked one. A broken arbiter shows up at the same latency, but only when two or more sources are eligible together. The stimulus table therefore pairs sources that differ in target level and sources that differ only in kind. A fault in the eligibility rule shows as a missing or extra take strobe when the global enable of the current level is toggled.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int NUM_LVL = 4;
  localparam int NUM_CLS = 3;
  localparam int NUM_SRC = NUM_LVL * NUM_CLS;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int CLS_W   = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int KEY_W   = LVL_W + CLS_W + LVL_W;
  localparam int NUM_W   = CLS_W + LVL_W;

  typedef enum logic [LVL_W-1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_H = 2'd2,
    LVL_M = 2'd3
  } priv_e;

  // kind codes match the cause-number base divided by four
  localparam int CLS_SW  = 0;
  localparam int CLS_TMR = 1;
  localparam int CLS_EXT = 2;

  // tie rank among kinds routed to one level: external, software, timer
  function automatic logic [CLS_W-1:0] cls_rank(input int cls);
    if (cls == CLS_EXT)     return CLS_W'(2);
    else if (cls == CLS_SW) return CLS_W'(1);
    else                    return CLS_W'(0);
  endfunction

endpackage

// File: rtl/irq_route_lane.sv
module irq_route_lane
  import irq_route_pkg::*;
#(
  parameter int SRC_IDX = 0
) (
  input  logic               act_i,
  input  logic               dm_i,
  input  logic               dh_i,
  input  logic               ds_i,
  input  logic [LVL_W-1:0]   cur_i,
  input  logic [NUM_LVL-1:0] gie_i,
  output logic               elig_o,
  output logic [LVL_W-1:0]   tgt_o,
  output logic [KEY_W-1:0]   key_o
);

  localparam int SRC_CLS = SRC_IDX / NUM_LVL;
  localparam int SRC_LVL = SRC_IDX % NUM_LVL;
  localparam logic [CLS_W-1:0] RANK = cls_rank(SRC_CLS);

  logic [LVL_W-1:0] tgt;

  // delegation chain: machine, then hypervisor, then supervisor
  always_comb begin
    if (!dm_i)      tgt = LVL_M;
    else if (!dh_i) tgt = LVL_H;
    else if (!ds_i) tgt = LVL_S;
    else            tgt = LVL_U;
  end

  logic above, same_ok;
  assign above   = (tgt > cur_i);
  assign same_ok = (tgt == cur_i) && gie_i[tgt];

  assign elig_o = act_i && (above || same_ok);
  assign tgt_o  = tgt;
  assign key_o  = {tgt, RANK, LVL_W'(SRC_LVL)};

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
  import irq_route_pkg::*;
(
  input  logic [NUM_SRC-1:0] elig_i,
  input  logic [KEY_W-1:0]   key_i [NUM_SRC],
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [KEY_W-1:0] best_key;

  // keys are unique per source, so a strict compare gives one winner
  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    best_key = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!valid_o || key_i[i] > best_key)) begin
        valid_o  = 1'b1;
        idx_o    = IDX_W'(i);
        best_key = key_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_route_cause.sv
module irq_route_cause
  import irq_route_pkg::*;
#(
  parameter int CAUSE_W = 64
) (
  input  logic               valid_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [LVL_W-1:0]   tgt_i,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam int PAD_W = CAUSE_W - 1 - NUM_W;

  logic [NUM_W-1:0] num;
  // kind base is four per kind, so the number packs as {kind, level}
  assign num = {cls_i, tgt_i};

  assign cause_o = valid_i ? {1'b1, {PAD_W{1'b0}}, num} : '0;

endmodule

// File: rtl/irq_deleg_router.sv
module irq_deleg_router
  import irq_route_pkg::*;
#(
  parameter int CAUSE_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [11:0]        pend_i,
  input  logic [11:0]        en_i,
  input  logic [11:0]        deleg_m_i,
  input  logic [11:0]        deleg_h_i,
  input  logic [11:0]        deleg_s_i,
  input  logic [3:0]         gie_i,
  input  logic [1:0]         cur_lvl_i,
  output logic               take_o,
  output logic [1:0]         tgt_lvl_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [3:0]         vec_sel_o
);

  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC-1:0] elig;
  logic [LVL_W-1:0]   lane_tgt [NUM_SRC];
  logic [KEY_W-1:0]   lane_key [NUM_SRC];

  assign act = pend_i & en_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    irq_route_lane #(.SRC_IDX(g)) u_lane (
      .act_i  (act[g]),
      .dm_i   (deleg_m_i[g]),
      .dh_i   (deleg_h_i[g]),
      .ds_i   (deleg_s_i[g]),
      .cur_i  (cur_lvl_i),
      .gie_i  (gie_i),
      .elig_o (elig[g]),
      .tgt_o  (lane_tgt[g]),
      .key_o  (lane_key[g])
    );
  end

  logic             win_vld;
  logic [IDX_W-1:0] win_idx;

  irq_route_arb u_arb (
    .elig_i  (elig),
    .key_i   (lane_key),
    .valid_o (win_vld),
    .idx_o   (win_idx)
  );

  logic [LVL_W-1:0]   win_tgt;
  logic [CLS_W-1:0]   win_cls;
  logic [CAUSE_W-1:0] win_cause;

  assign win_tgt = lane_tgt[win_idx];
  assign win_cls = win_idx[IDX_W-1:LVL_W];

  irq_route_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .valid_i (win_vld),
    .cls_i   (win_cls),
    .tgt_i   (win_tgt),
    .cause_o (win_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o    <= 1'b0;
      tgt_lvl_o <= '0;
      cause_o   <= '0;
      vec_sel_o <= '0;
    end else begin
      take_o    <= win_vld;
      tgt_lvl_o <= win_vld ? win_tgt : '0;
      cause_o   <= win_cause;
      vec_sel_o <= win_vld ? (NUM_LVL'(1) << win_tgt) : '0;
    end
  end

  AST_NOT_BELOW_CUR: assert property (@(posedge clk) disable iff (rst)
    take_o |-> tgt_lvl_o >= $past(cur_lvl_i)); // R4

  AST_SAME_LVL_GIE: assert property (@(posedge clk) disable iff (rst)
    (take_o && tgt_lvl_o == $past(cur_lvl_i)) |-> $past(gie_i[cur_lvl_i])); // R6

  AST_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(|(pend_i & en_i))); // R10

  AST_VSEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    take_o |-> vec_sel_o == (4'b0001 << tgt_lvl_o)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (vec_sel_o == 4'b0000 && cause_o == '0 && tgt_lvl_o == 2'd0)); // R3

  AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o[CAUSE_W-1] && cause_o[1:0] == tgt_lvl_o)); // R7

endmodule

// File: tb/test_irq_deleg_router.sv
module test_irq_deleg_router;

  localparam int CW = 64;
  localparam int NV = 17;

  typedef struct packed {
    logic [11:0] pend;
    logic [11:0] en;
    logic [11:0] dm;
    logic [11:0] dh;
    logic [11:0] ds;
    logic [3:0]  gie;
    logic [1:0]  cur;
    logic        take;
    logic [1:0]  tgt;
    logic [3:0]  num;
    logic [3:0]  req;
  } vec_t;

  // pend en dm dh ds gie cur | take tgt num | requirement
  localparam vec_t VECS [NV] = '{
    '{12'h080,12'h080,12'h000,12'h000,12'h000,4'h8,2'd3, 1'b1,2'd3,4'd7, 4'd6},  // R6 M at M, gie on
    '{12'h080,12'h080,12'h000,12'h000,12'h000,4'h0,2'd3, 1'b0,2'd0,4'd0, 4'd6},  // R6 gie off
    '{12'h080,12'h080,12'h080,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd2,4'd6, 4'd2},  // R2 to H
    '{12'h080,12'h080,12'h080,12'h080,12'h000,4'h0,2'd0, 1'b1,2'd1,4'd5, 4'd7},  // R7 timer to S
    '{12'h080,12'h080,12'h080,12'h080,12'h080,4'h1,2'd0, 1'b1,2'd0,4'd4, 4'd2},  // R2 to U
    '{12'h080,12'h080,12'h080,12'h080,12'h080,4'h0,2'd0, 1'b0,2'd0,4'd0, 4'd6},  // R6 U gie off
    '{12'h080,12'h080,12'h080,12'h080,12'h000,4'hF,2'd3, 1'b0,2'd0,4'd0, 4'd4},  // R4 S below M
    '{12'h080,12'h000,12'h000,12'h000,12'h000,4'hF,2'd0, 1'b0,2'd0,4'd0, 4'd10}, // R10 not enabled
    '{12'h888,12'hFFF,12'h000,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd3,4'd11,4'd9},  // R9 ext first
    '{12'h088,12'hFFF,12'h000,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd3,4'd3, 4'd9},  // R9 sw over timer
    '{12'h880,12'hFFF,12'h800,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd3,4'd7, 4'd8},  // R8 higher level
    '{12'h800,12'h800,12'h800,12'h800,12'h000,4'h2,2'd1, 1'b1,2'd1,4'd9, 4'd7},  // R7 ext to S
    '{12'h020,12'h020,12'h080,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd3,4'd7, 4'd2},  // R2 bit index
    '{12'h800,12'h800,12'h000,12'h000,12'h000,4'h0,2'd1, 1'b1,2'd3,4'd11,4'd5},  // R5 above, gie off
    '{12'h022,12'hFFF,12'h022,12'h022,12'h000,4'h0,2'd0, 1'b1,2'd1,4'd1, 4'd9},  // R9 sw over timer at S
    '{12'h111,12'hFFF,12'h111,12'h111,12'h111,4'hF,2'd1, 1'b0,2'd0,4'd0, 4'd4},  // R4 all U below S
    '{12'h888,12'h088,12'h000,12'h000,12'h000,4'h0,2'd0, 1'b1,2'd3,4'd3, 4'd10}  // R10 ext masked
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   pend_i = '0, en_i = '0, deleg_m_i = '0, deleg_h_i = '0, deleg_s_i = '0;
  logic [3:0]    gie_i = '0;
  logic [1:0]    cur_lvl_i = '0;
  logic          take_o;
  logic [1:0]    tgt_lvl_o;
  logic [CW-1:0] cause_o;
  logic [3:0]    vec_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_deleg_router #(.CAUSE_W(CW)) i_irq_deleg_router (
    .clk(clk), .rst(rst), .pend_i(pend_i), .en_i(en_i),
    .deleg_m_i(deleg_m_i), .deleg_h_i(deleg_h_i), .deleg_s_i(deleg_s_i),
    .gie_i(gie_i), .cur_lvl_i(cur_lvl_i),
    .take_o(take_o), .tgt_lvl_o(tgt_lvl_o), .cause_o(cause_o), .vec_sel_o(vec_sel_o)
  );

  function automatic logic [CW-1:0] exp_cause(input logic t, input logic [3:0] n);
    return t ? ((CW'(1) << (CW-1)) | CW'(n)) : '0;
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic t, input logic [1:0] l, input logic [3:0] n);
    check({tag, " take"},  CW'(take_o), CW'(t));
    check({tag, " level"}, CW'(tgt_lvl_o), t ? CW'(l) : '0);
    check({tag, " cause"}, cause_o, exp_cause(t, n));
    check({tag, " vsel (R3)"}, CW'(vec_sel_o), t ? CW'(4'b0001 << l) : '0);
  endtask

  task automatic drive(input vec_t v);
    pend_i = v.pend; en_i = v.en; deleg_m_i = v.dm; deleg_h_i = v.dh;
    deleg_s_i = v.ds; gie_i = v.gie; cur_lvl_i = v.cur;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 1'b0, 2'd0, 4'd0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 idle after reset", 1'b0, 2'd0, 4'd0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(posedge clk);
      @(negedge clk);
      check_all($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].take, VECS[k].tgt, VECS[k].num);
    end

    // R11: latency of one edge, strobe held, then dropped
    drive(VECS[1]);
    @(posedge clk); @(negedge clk);
    drive(VECS[0]);
    #2;
    check("R11 before edge", CW'(take_o), CW'(1'b0));
    @(posedge clk); @(negedge clk);
    check_all("R11 after edge", 1'b1, 2'd3, 4'd7);
    @(posedge clk); @(negedge clk);
    check_all("R11 held", 1'b1, 2'd3, 4'd7);
    pend_i = '0;
    @(posedge clk); @(negedge clk);
    check_all("R11 dropped", 1'b0, 2'd0, 4'd0);

    // R1: reset wins over an eligible source
    drive(VECS[2]);
    @(posedge clk); @(negedge clk);
    check_all("R1 pre-reset", 1'b1, 2'd2, 4'd6);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_all("R1 mid-run reset", 1'b0, 2'd0, 4'd0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_all("R1 release", 1'b1, 2'd2, 4'd6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule